// File: doc/BRIEF.md
# Serial Object Cut Evaluator

This block judges one single-object trigger condition on a fast processing clock that runs at twelve times the bunch-crossing rate. The objects of one event arrive one per fast cycle on a stream with a valid strobe and markers for the first and last object. Every object already carries its transverse momentum, pseudorapidity, azimuth and longitudinal vertex position on a common scale. A single shared comparator stage checks each object in turn against configured cuts. A counter collects the per-object results over the event, and one registered decision is issued when the event ends.

The cuts are a momentum threshold (passes when greater than or equal) and three inclusive windows on the coordinates. Each cut has its own enable bit. The condition asks for a minimum number of passing objects, N from 1 to 4. Thresholds are written through a small address/data port into a shadow bank. The values that are judged are copied from that bank only when a new event begins.

Top module: `obj_cut_eval`

## Requirements
- R1: After reset `dec_valid` and `dec_pass` are low, and they stay low until an event's last-marked object has been accepted.
- R2: With the momentum cut enabled (ctrl bit 0), an object passes that cut only when `s_pt` is greater than or equal to the threshold at address 0.
- R3: With a coordinate window enabled (ctrl bit 1 eta, bit 2 phi, bit 3 z0), an object passes only when the signed value lies between the lower bound and the upper bound, both bounds included. The lower and upper bounds sit at addresses 1/2 (eta), 3/4 (phi) and 5/6 (z0).
- R4: When a cut's enable bit is clear, that cut passes any value.
- R5: The decision is true when the count of passing objects in the event is at least N. N is ctrl bits [5:4] plus one. The count saturates at 4, so events with more than 4 passing objects still pass any N.
- R6: A cycle with `s_valid` low never counts as a passing object, and its first and last markers are ignored.
- R7: `dec_valid` pulses high for one cycle exactly 3 fast cycles after the cycle that carries the valid last-marked object. The latency is the same for every object count, including a one-object event with both markers set.
- R8: A configuration write changes only the shadow bank. The shadow is copied into the active cuts when a valid first-marked object is accepted, so an event in progress is always judged entirely with the cuts in force at its start.
- R9: `dec_pass` is high only while `dec_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Object slot carries a real object |
| s_first | input | 1 | Object is the first of its event |
| s_last | input | 1 | Object is the last of its event |
| s_pt | input | PT_W | Transverse momentum, common scale, unsigned |
| s_eta | input | COORD_W | Pseudorapidity, common scale |
| s_phi | input | COORD_W | Azimuth, common scale |
| s_z0 | input | COORD_W | Longitudinal vertex position, common scale |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address (0..7, 7 = control) |
| cfg_data | input | CFG_W | Configuration write data |
| dec_valid | output | 1 | Decision strobe, one cycle per event |
| dec_pass | output | 1 | Condition result for the finished event |

## Verification
The hardest situation to reach is a configuration write that lands while an event is still flowing through the comparator and counter. It requires the thresholds seen by objects already in the pipeline to differ from those in the shadow bank. The bench issues a write to the momentum threshold in the middle of an event's slot sequence. It then checks that this event is still judged with the old threshold and that the next event sees the new one. Invalid slots that carry passing data are placed in the middle of events, and single-object events are sent back to back with multi-object ones. These cases show that the latency and the count do not depend on event shape.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
   localparam int unsigned NUM_WIN = 3;
   localparam int unsigned EN_BITS = NUM_WIN + 1;

   typedef enum logic [2:0] {
      A_PT_THR = 3'd0,
      A_ETA_LO = 3'd1,
      A_ETA_HI = 3'd2,
      A_PHI_LO = 3'd3,
      A_PHI_HI = 3'd4,
      A_Z0_LO  = 3'd5,
      A_Z0_HI  = 3'd6,
      A_CTRL   = 3'd7
   } cfg_addr_e;
endpackage

// File: rtl/tmc_cfg_bank.sv
module tmc_cfg_bank
   import tmc_pkg::*;
#(
   parameter int unsigned PT_W    = 12,
   parameter int unsigned COORD_W = 10,
   parameter int unsigned NEED_W  = 2,
   parameter int unsigned CFG_W   = 12
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [2:0]                           wr_addr,
   input  logic [CFG_W-1:0]                     wr_data,
   input  logic                                 load,
   output logic [PT_W-1:0]                      act_pt_thr,
   output logic [NUM_WIN-1:0][COORD_W-1:0]      act_lo,
   output logic [NUM_WIN-1:0][COORD_W-1:0]      act_hi,
   output logic [EN_BITS-1:0]                   act_en,
   output logic [NEED_W-1:0]                    act_need
);
   logic [PT_W-1:0]                 sh_pt_thr;
   logic [NUM_WIN-1:0][COORD_W-1:0] sh_lo, sh_hi;
   logic [EN_BITS-1:0]              sh_en;
   logic [NEED_W-1:0]               sh_need;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_pt_thr <= '0;
         sh_lo     <= '0;
         sh_hi     <= '0;
         sh_en     <= '0;
         sh_need   <= '0;
      end else if (wr_en) begin
         case (cfg_addr_e'(wr_addr))
            A_PT_THR: sh_pt_thr <= wr_data[PT_W-1:0];
            A_ETA_LO: sh_lo[0]  <= wr_data[COORD_W-1:0];
            A_ETA_HI: sh_hi[0]  <= wr_data[COORD_W-1:0];
            A_PHI_LO: sh_lo[1]  <= wr_data[COORD_W-1:0];
            A_PHI_HI: sh_hi[1]  <= wr_data[COORD_W-1:0];
            A_Z0_LO:  sh_lo[2]  <= wr_data[COORD_W-1:0];
            A_Z0_HI:  sh_hi[2]  <= wr_data[COORD_W-1:0];
            A_CTRL: begin
               sh_en   <= wr_data[EN_BITS-1:0];
               sh_need <= wr_data[EN_BITS +: NEED_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pt_thr <= '0;
         act_lo     <= '0;
         act_hi     <= '0;
         act_en     <= '0;
         act_need   <= '0;
      end else if (load) begin
         act_pt_thr <= sh_pt_thr;
         act_lo     <= sh_lo;
         act_hi     <= sh_hi;
         act_en     <= sh_en;
         act_need   <= sh_need;
      end
   end

   // R8: active cuts move only on an event start
   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_pt_thr) && $stable(act_en) && $stable(act_need)
                 && $stable(act_lo) && $stable(act_hi)));
endmodule

// File: rtl/tmc_cut_stage.sv
module tmc_cut_stage
   import tmc_pkg::*;
#(
   parameter int unsigned PT_W         = 12,
   parameter int unsigned COORD_W      = 10,
   parameter int unsigned NEED_W       = 2,
   parameter bit          SIGNED_COORD = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_first,
   input  logic                            in_last,
   input  logic [PT_W-1:0]                 in_pt,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] in_coord,
   input  logic [PT_W-1:0]                 pt_thr,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_lo,
   input  logic [NUM_WIN-1:0][COORD_W-1:0] win_hi,
   input  logic [EN_BITS-1:0]              cut_en,
   input  logic [NEED_W-1:0]               need,
   output logic                            res_valid,
   output logic                            res_first,
   output logic                            res_last,
   output logic                            res_pass,
   output logic [NEED_W-1:0]               res_need
);
   // stage A: object register
   logic                            a_v, a_f, a_l;
   logic [PT_W-1:0]                 a_pt;
   logic [NUM_WIN-1:0][COORD_W-1:0] a_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_v  <= 1'b0;
         a_f  <= 1'b0;
         a_l  <= 1'b0;
         a_pt <= '0;
         a_c  <= '0;
      end else begin
         a_v  <= in_valid;
         a_f  <= in_valid & in_first;
         a_l  <= in_valid & in_last;
         a_pt <= in_pt;
         a_c  <= in_coord;
      end
   end

   // shared comparators
   logic               pt_ok;
   logic [NUM_WIN-1:0] win_ok;

   assign pt_ok = !cut_en[0] || (a_pt >= pt_thr);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic ge_lo, le_hi;
      if (SIGNED_COORD) begin : g_signed
         assign ge_lo = $signed(a_c[w]) >= $signed(win_lo[w]);
         assign le_hi = $signed(a_c[w]) <= $signed(win_hi[w]);
      end else begin : g_unsigned
         assign ge_lo = a_c[w] >= win_lo[w];
         assign le_hi = a_c[w] <= win_hi[w];
      end
      assign win_ok[w] = !cut_en[w+1] || (ge_lo && le_hi);
   end

   // stage B: result register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_first <= 1'b0;
         res_last  <= 1'b0;
         res_pass  <= 1'b0;
         res_need  <= '0;
      end else begin
         res_valid <= a_v;
         res_first <= a_f;
         res_last  <= a_l;
         res_pass  <= a_v && pt_ok && (&win_ok);
         res_need  <= need;
      end
   end

   // R6: an empty slot never yields a passing result
   assert_empty_no_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !res_pass);
endmodule

// File: rtl/tmc_mult_acc.sv
module tmc_mult_acc #(
   parameter int unsigned MAX_MULT = 4,
   parameter int unsigned NEED_W   = 2,
   localparam int unsigned CNT_W   = $clog2(MAX_MULT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic              res_first,
   input  logic              res_last,
   input  logic              res_pass,
   input  logic [NEED_W-1:0] res_need,
   output logic              dec_valid,
   output logic              dec_pass
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_MULT);

   logic [CNT_W-1:0] cnt, base, cnt_nx, need_cnt;

   assign base     = res_first ? '0 : cnt;
   assign cnt_nx   = (res_pass && (base != CNT_MAX)) ? base + CNT_W'(1) : base;
   assign need_cnt = CNT_W'(res_need) + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         dec_valid <= 1'b0;
         dec_pass  <= 1'b0;
      end else begin
         if (res_valid) cnt <= cnt_nx;
         dec_valid <= res_valid && res_last;
         dec_pass  <= res_valid && res_last && (cnt_nx >= need_cnt);
      end
   end

   // R5: the count saturates
   assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);
   // R6: empty slots leave the count untouched
   assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(cnt));
endmodule

// File: rtl/obj_cut_eval.sv
module obj_cut_eval
   import tmc_pkg::*;
#(
   parameter int unsigned PT_W         = 12,
   parameter int unsigned COORD_W      = 10,
   parameter int unsigned MAX_MULT     = 4,
   parameter bit          SIGNED_COORD = 1'b1,
   localparam int unsigned NEED_W      = $clog2(MAX_MULT),
   localparam int unsigned CTRL_W      = EN_BITS + NEED_W,
   localparam int unsigned CFG_W0      = (PT_W > COORD_W) ? PT_W : COORD_W,
   localparam int unsigned CFG_W       = (CFG_W0 > CTRL_W) ? CFG_W0 : CTRL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_valid,
   input  logic               s_first,
   input  logic               s_last,
   input  logic [PT_W-1:0]    s_pt,
   input  logic [COORD_W-1:0] s_eta,
   input  logic [COORD_W-1:0] s_phi,
   input  logic [COORD_W-1:0] s_z0,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [CFG_W-1:0]   cfg_data,
   output logic               dec_valid,
   output logic               dec_pass
);
   initial begin
      assert (MAX_MULT >= 2 && (1 << NEED_W) == MAX_MULT)
         else $error("MAX_MULT must be a power of two of at least 2");
      assert (PT_W >= 2 && COORD_W >= 2) else $error("field widths too small");
   end

   logic [PT_W-1:0]                 pt_thr;
   logic [NUM_WIN-1:0][COORD_W-1:0] lo, hi, coord;
   logic [EN_BITS-1:0]              en;
   logic [NEED_W-1:0]               need, r_need;
   logic                            r_v, r_f, r_l, r_p;

   assign coord = {s_z0, s_phi, s_eta};

   tmc_cfg_bank #(.PT_W(PT_W), .COORD_W(COORD_W), .NEED_W(NEED_W), .CFG_W(CFG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
      .load(s_valid & s_first),
      .act_pt_thr(pt_thr), .act_lo(lo), .act_hi(hi), .act_en(en), .act_need(need)
   );

   tmc_cut_stage #(.PT_W(PT_W), .COORD_W(COORD_W), .NEED_W(NEED_W),
                   .SIGNED_COORD(SIGNED_COORD)) u_cut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s_valid), .in_first(s_first), .in_last(s_last),
      .in_pt(s_pt), .in_coord(coord),
      .pt_thr(pt_thr), .win_lo(lo), .win_hi(hi), .cut_en(en), .need(need),
      .res_valid(r_v), .res_first(r_f), .res_last(r_l), .res_pass(r_p), .res_need(r_need)
   );

   tmc_mult_acc #(.MAX_MULT(MAX_MULT), .NEED_W(NEED_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .res_valid(r_v), .res_first(r_f), .res_last(r_l), .res_pass(r_p), .res_need(r_need),
      .dec_valid(dec_valid), .dec_pass(dec_pass)
   );

   // R7: fixed latency from the last object
   assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(s_valid && s_last, 3));
   // R9: result qualified by strobe
   assert_pass_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_pass |-> dec_valid);
endmodule

// File: tb/test_obj_cut_eval.sv
module test_obj_cut_eval;
   localparam int PT_W = 12;
   localparam int CW   = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
   logic [PT_W-1:0] s_pt = '0;
   logic [CW-1:0] s_eta = '0, s_phi = '0, s_z0 = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [11:0]   cfg_data = '0;
   logic          dec_valid, dec_pass;

   int checks = 0, errors = 0;
   int cyc = 0, pulses = 0, seen_cyc = 0, last_cyc = 0;
   logic seen_pass = 1'b0;
   logic stray = 1'b0;

   // per-slot stimulus
   int  o_pt [12];
   int  o_eta[12];
   int  o_phi[12];
   int  o_z0 [12];
   bit  o_val[12];

   obj_cut_eval i_obj_cut_eval (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_first(s_first), .s_last(s_last),
      .s_pt(s_pt), .s_eta(s_eta), .s_phi(s_phi), .s_z0(s_z0),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .dec_valid(dec_valid), .dec_pass(dec_pass));

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (dec_valid) begin
         pulses    <= pulses + 1;
         seen_cyc  <= cyc;
         seen_pass <= dec_pass;
      end
      if (dec_pass && !dec_valid) stray <= 1'b1;
   end

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_data = 12'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // ctrl: bits[3:0] enables pt/eta/phi/z0, bits[5:4] = N-1
   task automatic set_ctrl(input int en, input int n);
      cfg_write(7, en | ((n - 1) << 4));
   endtask

   task automatic clear_slots();
      for (int i = 0; i < 12; i++) begin
         o_pt[i] = 0; o_eta[i] = 0; o_phi[i] = 0; o_z0[i] = 0; o_val[i] = 1'b1;
      end
   endtask

   // drive n slots; optional config write on slot wr_slot
   task automatic run_event(input int n, input int exp, input string req,
                            input int wr_slot = -1, input int wr_a = 0, input int wr_d = 0);
      int p0;
      int first_v, last_v;
      first_v = -1; last_v = -1;
      for (int i = 0; i < n; i++) if (o_val[i]) begin
         if (first_v < 0) first_v = i;
         last_v = i;
      end
      p0 = pulses;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s_valid = o_val[i];
         s_first = (i == first_v) || !o_val[i];
         s_last  = (i == last_v)  || !o_val[i];
         s_pt = PT_W'(o_pt[i]); s_eta = CW'(o_eta[i]);
         s_phi = CW'(o_phi[i]); s_z0 = CW'(o_z0[i]);
         cfg_we = (i == wr_slot); cfg_addr = 3'(wr_a); cfg_data = 12'(wr_d);
         if (i == last_v) last_cyc = cyc;
      end
      @(negedge clk);
      s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0; cfg_we = 1'b0;
      repeat (5) @(negedge clk);
      check({req, " pulse count"}, pulses - p0, 1);
      check({req, " decision"}, int'(seen_pass), exp);
      check("R7 latency", seen_cyc - last_cyc, 3);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 dec_valid after reset", int'(dec_valid), 0);
      check("R1 dec_pass after reset", int'(dec_pass), 0);
      check("R1 no pulse in reset", pulses, 0);
   endtask

   task automatic t_pt();
      cfg_write(0, 100); set_ctrl(1, 1);
      clear_slots(); o_pt[0] = 100; run_event(1, 1, "R2 pt equal threshold");
      clear_slots(); o_pt[0] = 99;  run_event(1, 0, "R2 pt below threshold");
      clear_slots(); o_pt[0] = 4095; run_event(1, 1, "R2 pt max");
   endtask

   task automatic t_windows();
      cfg_write(0, 0);
      cfg_write(1, -20); cfg_write(2, 20);
      cfg_write(3, 5);   cfg_write(4, 300);
      cfg_write(5, -100); cfg_write(6, -10);
      set_ctrl(4'hE, 1);
      clear_slots(); o_eta[0] = -20; o_phi[0] = 300; o_z0[0] = -100;
      run_event(1, 1, "R3 all bounds inclusive");
      clear_slots(); o_eta[0] = 21; o_phi[0] = 10; o_z0[0] = -50;
      run_event(1, 0, "R3 eta above window");
      clear_slots(); o_eta[0] = 0; o_phi[0] = 4; o_z0[0] = -50;
      run_event(1, 0, "R3 phi below window");
      clear_slots(); o_eta[0] = 0; o_phi[0] = 10; o_z0[0] = -9;
      run_event(1, 0, "R3 z0 above window");
      set_ctrl(4'h4, 1);
      clear_slots(); o_eta[0] = 400; o_phi[0] = 10; o_z0[0] = 400;
      run_event(1, 1, "R4 disabled windows ignored");
   endtask

   task automatic t_mult();
      cfg_write(0, 50); set_ctrl(1, 3);
      clear_slots(); o_pt[2] = 60; o_pt[7] = 50;
      run_event(12, 0, "R5 two of three");
      clear_slots(); o_pt[0] = 60; o_pt[5] = 51; o_pt[11] = 70;
      run_event(12, 1, "R5 three of three");
      set_ctrl(1, 4);
      clear_slots(); for (int i = 0; i < 12; i++) o_pt[i] = 80;
      run_event(12, 1, "R5 saturated twelve of four");
      clear_slots(); o_pt[1] = 80; o_pt[3] = 80; o_pt[4] = 80;
      run_event(5, 0, "R5 three of four");
   endtask

   task automatic t_invalid();
      cfg_write(0, 50); set_ctrl(1, 2);
      clear_slots();
      o_pt[0] = 60; o_pt[3] = 90; o_val[3] = 1'b0; o_pt[6] = 90; o_val[6] = 1'b0;
      run_event(8, 0, "R6 invalid slots not counted");
      clear_slots(); o_pt[0] = 60; o_pt[4] = 60; o_val[2] = 1'b0;
      run_event(8, 1, "R6 valid slots around gap");
   endtask

   task automatic t_cfg_midevent();
      cfg_write(0, 50); set_ctrl(1, 1);
      clear_slots(); o_pt[9] = 60;
      run_event(12, 1, "R8 old threshold kept in event", 4, 0, 70);
      clear_slots(); o_pt[0] = 60;
      run_event(1, 0, "R8 new threshold next event");
      check("R9 pass only with valid", int'(stray), 0);
   endtask

   initial begin
      clear_slots();
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after release", pulses, 0);
      t_pt();
      t_windows();
      t_mult();
      t_invalid();
      t_cfg_midevent();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule